// File: doc/BRIEF.md
# Video Slot and Line Timing Generator

This block produces the raster timing for a tile-based video processor from its master clock. A horizontal slot counter steps through the slots of each scan line. Each slot costs a number of master clocks that depends on the display width and, in the wide layout, on where the slot sits within the sync window. A vertical line counter steps once per line and wraps at the end of the frame. The block also produces horizontal and vertical blanking flags, a single-clock strobe at each line change, and a vertical interrupt request.

The width select picks between a 40-cell and a 32-cell schedule. It is taken in only when the slot counter enters slot 0, so no line mixes the two schedules. Both schedules add up to 3420 master clocks per line. A separate mode input chooses whether the interrupt comes on the first inactive line or on the line after it.

Top module: `slot_timing_gen`

## Requirements
- R1: With the 40-cell schedule the slot counter runs 0..182, then moves directly to 229, then runs 229..255 and wraps to 0, for 210 slots per line.
- R2: With the 32-cell schedule the slot counter runs 0..147, then moves directly to 233, then runs 233..255 and wraps to 0, for 171 slots per line.
- R3: A 32-cell slot lasts 20 master clocks. A 40-cell slot lasts 16 master clocks, except slots 230..246, which last 19,20,20,20,18,20,20,20,18,20,20,20,18,20,20,20,19 clocks in ascending slot order. The length charged is the length of the slot being left.
- R4: With a fixed width, successive line strobes are exactly 3420 master clocks apart.
- R5: `line_adv` is high for the first clock of slot 165 (40-cell) or slot 133 (32-cell). In that same clock `vline` holds the incremented line number, which wraps from LINES-1 to 0.
- R6: `vblank` changes only on entry to the slot two after the line-change slot (167 or 135). It then takes the value (vline >= inactive_line).
- R7: `hblank` is high exactly when the slot is at or above 178 (40-cell) or at or above 233 (32-cell), so it ends at slot 0.
- R8: With `irq_en` high, `vint_req` rises on entry to slot 167/135 of line inactive_line when `mode5` is 1, or of line inactive_line+1 when `mode5` is 0. It stays high until the next line strobe.
- R9: `vint_req` is low whenever `irq_en` is low.
- R10: The width select is sampled only on entry to slot 0; after reset the 40-cell schedule is in force.
- R11: During reset `hslot`, `vline`, `hblank`, `vblank`, `line_adv` and `vint_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1 selects the 40-cell schedule, 0 the 32-cell schedule |
| mode5 | input | 1 | 1 raises the interrupt on the first inactive line, 0 one line later |
| irq_en | input | 1 | Vertical interrupt enable |
| inactive_line | input | VL_W | First line of the inactive region |
| hslot | output | 8 | Current horizontal slot |
| vline | output | VL_W | Current line |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| line_adv | output | 1 | One-clock strobe at each line change |
| vint_req | output | 1 | Vertical interrupt request |

## Verification
The slot number, line number, line strobe, vblank and the stored interrupt flag all update on the clock edge where the current slot's clock count runs out, so each is visible in the first clock of the new slot. `hblank` and the enable gating on `vint_req` are combinational and follow `hslot` and `irq_en` within the same clock. The bench samples every output on the falling clock edge and drives inputs just after a falling edge. Every comparison therefore looks at the state settled by the preceding rising edge: the length of a slot is counted in falling edges between slot changes, and the length of a line in falling edges between strobes.

// File: rtl/slot_timing_pkg.sv
package slot_timing_pkg;

  localparam int CNT_W = 5;

  typedef logic [7:0] slot_t;

  localparam slot_t WIDE_LAST      = 8'd182;
  localparam slot_t WIDE_RESUME    = 8'd229;
  localparam slot_t NARROW_LAST    = 8'd147;
  localparam slot_t NARROW_RESUME  = 8'd233;
  localparam slot_t SYNC_FIRST     = 8'd230;
  localparam slot_t SYNC_END       = 8'd247;
  localparam slot_t WIDE_LC        = 8'd165;
  localparam slot_t NARROW_LC      = 8'd133;
  localparam slot_t VB_DELAY       = 8'd2;
  localparam slot_t WIDE_HB        = 8'd178;
  localparam slot_t NARROW_HB      = 8'd233;

  localparam logic [CNT_W-1:0] WIDE_SLOT_LEN   = 5'd16;
  localparam logic [CNT_W-1:0] NARROW_SLOT_LEN = 5'd20;

  // Clock cost of each slot inside the wide sync window, by offset.
  function automatic logic [CNT_W-1:0] sync_len(input logic [4:0] idx);
    case (idx)
      5'd0, 5'd16:       sync_len = 5'd19;
      5'd4, 5'd8, 5'd12: sync_len = 5'd18;
      default:           sync_len = 5'd20;
    endcase
  endfunction

endpackage

// File: rtl/slot_len_rom.sv
module slot_len_rom
  import slot_timing_pkg::*;
(
  input  slot_t            slot_i,
  input  logic             wide_i,
  output logic [CNT_W-1:0] len_o
);

  logic       in_sync;
  logic [4:0] offs;

  always_comb begin
    offs    = 5'(slot_i - SYNC_FIRST);
    in_sync = (slot_i >= SYNC_FIRST) && (slot_i < SYNC_END);
    if (!wide_i)      len_o = NARROW_SLOT_LEN;
    else if (in_sync) len_o = sync_len(offs);
    else              len_o = WIDE_SLOT_LEN;
  end

endmodule

// File: rtl/hslot_ctr.sv
module hslot_ctr
  import slot_timing_pkg::*;
#(
  parameter bit RESET_WIDE = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wide_mode_i,
  output slot_t slot_o,
  output logic  wide_o,
  output logic  adv_o,
  output slot_t slot_nxt_o
);

  slot_t            slot_q, slot_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_d, len;
  logic             wide_q, wide_load, last;

  slot_len_rom u_len (
    .slot_i (slot_q),
    .wide_i (wide_q),
    .len_o  (len)
  );

  always_comb begin
    last = (cnt_q == len - 1'b1);
    if (wide_q && slot_q == WIDE_LAST)          slot_nxt = WIDE_RESUME;
    else if (!wide_q && slot_q == NARROW_LAST)  slot_nxt = NARROW_RESUME;
    else                                        slot_nxt = slot_q + 8'd1;
    cnt_d     = last ? '0 : cnt_q + 1'b1;
    wide_load = last && (slot_nxt == 8'd0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slot_q <= '0;
      wide_q <= RESET_WIDE;
    end else begin
      cnt_q <= cnt_d;
      if (last)      slot_q <= slot_nxt;
      if (wide_load) wide_q <= wide_mode_i;
    end
  end

  assign slot_o     = slot_q;
  assign wide_o     = wide_q;
  assign adv_o      = last;
  assign slot_nxt_o = slot_nxt;

  AST_WIDE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (last && wide_q && slot_q == WIDE_LAST) |=> (slot_q == WIDE_RESUME)); // R1
  AST_NARROW_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !wide_q && slot_q == NARROW_LAST) |=> (slot_q == NARROW_RESUME)); // R2
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(slot_q)); // R3
  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q != 8'd0) |-> $stable(wide_q)); // R10

endmodule

// File: rtl/vline_ctr.sv
module vline_ctr
  import slot_timing_pkg::*;
#(
  parameter int LINES = 262,
  parameter int VL_W  = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_i,
  input  slot_t           slot_nxt_i,
  input  logic            wide_i,
  input  logic            mode5_i,
  input  logic [VL_W-1:0] inactive_i,
  output logic [VL_W-1:0] line_o,
  output logic            vblank_o,
  output logic            line_adv_o,
  output logic            vint_o
);

  localparam logic [VL_W-1:0] LAST_LINE = VL_W'(LINES - 1);

  logic [VL_W-1:0] line_q, line_d, vint_line;
  slot_t           lc_slot, vb_slot;
  logic            lc_hit, vb_hit;
  logic            vblank_q, line_adv_q, vint_q, vint_d;

  always_comb begin
    lc_slot   = wide_i ? WIDE_LC : NARROW_LC;
    vb_slot   = lc_slot + VB_DELAY;
    lc_hit    = adv_i && (slot_nxt_i == lc_slot);
    vb_hit    = adv_i && (slot_nxt_i == vb_slot);
    line_d    = (line_q == LAST_LINE) ? '0 : line_q + 1'b1;
    vint_line = mode5_i ? inactive_i : inactive_i + 1'b1;
    if (vb_hit)      vint_d = (line_q == vint_line);
    else if (lc_hit) vint_d = 1'b0;
    else             vint_d = vint_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q     <= '0;
      vblank_q   <= 1'b0;
      line_adv_q <= 1'b0;
      vint_q     <= 1'b0;
    end else begin
      line_adv_q <= lc_hit;
      vint_q     <= vint_d;
      if (lc_hit) line_q   <= line_d;
      if (vb_hit) vblank_q <= (line_q >= inactive_i);
    end
  end

  assign line_o     = line_q;
  assign vblank_o   = vblank_q;
  assign line_adv_o = line_adv_q;
  assign vint_o     = vint_q;

  AST_VB_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vblank_q) || $fell(vblank_q)) |-> $past(vb_hit)); // R6
  AST_VINT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vint_q) |-> (line_q == $past(vint_line))); // R8
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    line_adv_q |-> (line_q != $past(line_q))); // R5

endmodule

// File: rtl/slot_timing_gen.sv
module slot_timing_gen
  import slot_timing_pkg::*;
#(
  parameter int LINES      = 262,
  parameter int VL_W       = 9,
  parameter bit RESET_WIDE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wide_mode,
  input  logic            mode5,
  input  logic            irq_en,
  input  logic [VL_W-1:0] inactive_line,
  output logic [7:0]      hslot,
  output logic [VL_W-1:0] vline,
  output logic            hblank,
  output logic            vblank,
  output logic            line_adv,
  output logic            vint_req
);

  slot_t slot_cur, slot_nxt;
  logic  wide_cur, adv, vint_flag;

  hslot_ctr #(.RESET_WIDE(RESET_WIDE)) u_hslot (
    .clk         (clk),
    .rst_n       (rst_n),
    .wide_mode_i (wide_mode),
    .slot_o      (slot_cur),
    .wide_o      (wide_cur),
    .adv_o       (adv),
    .slot_nxt_o  (slot_nxt)
  );

  vline_ctr #(.LINES(LINES), .VL_W(VL_W)) u_vline (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (adv),
    .slot_nxt_i (slot_nxt),
    .wide_i     (wide_cur),
    .mode5_i    (mode5),
    .inactive_i (inactive_line),
    .line_o     (vline),
    .vblank_o   (vblank),
    .line_adv_o (line_adv),
    .vint_o     (vint_flag)
  );

  assign hslot    = slot_cur;
  assign hblank   = slot_cur >= (wide_cur ? WIDE_HB : NARROW_HB);
  assign vint_req = vint_flag & irq_en;

endmodule

// File: tb/test_slot_timing_gen.sv
module test_slot_timing_gen;

  localparam int CLK_PERIOD = 10;
  localparam int LINES      = 8;
  localparam int VL_W       = 9;
  localparam int INACT      = 5;
  localparam int LINE_CLKS  = 3420;
  localparam int WD_LIMIT   = 195000;

  logic            clk = 1'b0;
  logic            rst_n, wide_mode, mode5, irq_en;
  logic [VL_W-1:0] inactive_line;
  logic [7:0]      hslot;
  logic [VL_W-1:0] vline;
  logic            hblank, vblank, line_adv, vint_req;

  int checks = 0;
  int fails  = 0;

  slot_timing_gen #(.LINES(LINES), .VL_W(VL_W)) i_slot_timing_gen (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .mode5(mode5),
    .irq_en(irq_en), .inactive_line(inactive_line), .hslot(hslot),
    .vline(vline), .hblank(hblank), .vblank(vblank),
    .line_adv(line_adv), .vint_req(vint_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int m_dur(input int s, input bit w);
    if (!w) return 20;
    if (s < 230 || s > 246) return 16;
    case (s - 230)
      0, 16:    return 19;
      4, 8, 12: return 18;
      default:  return 20;
    endcase
  endfunction

  function automatic int m_succ(input int s, input bit w);
    if (w && s == 182)  return 229;
    if (!w && s == 147) return 233;
    return (s + 1) % 256;
  endfunction

  function automatic int m_lc(input bit w);
    return w ? 165 : 133;
  endfunction

  function automatic int m_hb(input bit w);
    return w ? 178 : 233;
  endfunction

  // Monitor state
  int prev_slot, slot_clk, exp_line, lcnt, lines_seen, rises;
  bit cur_w, armed, skip, prev_vb, prev_vi;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_slot = 0; slot_clk = 0; cur_w = 1'b1; exp_line = 0;
      armed = 1'b0; skip = 1'b0; lcnt = 0; prev_vb = 1'b0; prev_vi = 1'b0;
    end else begin
      lcnt++;
      if (int'(hslot) != prev_slot) begin
        chk(slot_clk + 1 == m_dur(prev_slot, cur_w), "R3 slot length", slot_clk + 1, m_dur(prev_slot, cur_w));
        if (wide_mode != cur_w)
          chk(int'(hslot) == m_succ(prev_slot, cur_w), "R10 old schedule kept", hslot, m_succ(prev_slot, cur_w));
        else if (cur_w)
          chk(int'(hslot) == m_succ(prev_slot, cur_w), "R1 wide successor", hslot, m_succ(prev_slot, cur_w));
        else
          chk(int'(hslot) == m_succ(prev_slot, cur_w), "R2 narrow successor", hslot, m_succ(prev_slot, cur_w));
        if (hslot == 8'd0) begin
          if (wide_mode != cur_w) skip = 1'b1;
          cur_w = wide_mode;
        end
        chk(hblank == (int'(hslot) >= m_hb(cur_w)), "R7 hblank", hblank, int'(hslot) >= m_hb(cur_w));
        slot_clk  = 0;
        prev_slot = hslot;
      end else begin
        slot_clk++;
      end

      if (line_adv) begin
        chk(int'(hslot) == m_lc(cur_w), "R5 strobe slot", hslot, m_lc(cur_w));
        exp_line = (exp_line + 1) % LINES;
        chk(int'(vline) == exp_line, "R5 line number", vline, exp_line);
        if (armed && !skip) chk(lcnt == LINE_CLKS, "R4 line length", lcnt, LINE_CLKS);
        skip  = 1'b0;
        armed = 1'b1;
        lcnt  = 0;
        lines_seen++;
      end

      if (vblank != prev_vb) begin
        chk(int'(hslot) == m_lc(cur_w) + 2, "R6 vblank slot", hslot, m_lc(cur_w) + 2);
        chk(vblank == (int'(vline) >= INACT), "R6 vblank value", vblank, int'(vline) >= INACT);
      end

      if (vint_req && !prev_vi) begin
        rises++;
        chk(int'(hslot) == m_lc(cur_w) + 2, "R8 vint slot", hslot, m_lc(cur_w) + 2);
        chk(int'(vline) == (mode5 ? INACT : INACT + 1), "R8 vint line", vline, mode5 ? INACT : INACT + 1);
      end
      if (!vint_req && prev_vi && irq_en)
        chk(line_adv, "R8 vint held to strobe", line_adv, 1);
      if (!irq_en)
        chk(!vint_req, "R9 vint gated", vint_req, 0);

      prev_vb = vblank;
      prev_vi = vint_req;
    end
  end

  task automatic wait_lines(input int n);
    int start = lines_seen;
    while (lines_seen < start + n) @(negedge clk);
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", WD_LIMIT, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int r0;
    lines_seen = 0; rises = 0;
    rst_n = 1'b0; wide_mode = 1'b1; mode5 = 1'b1; irq_en = 1'b1;
    inactive_line = VL_W'(INACT);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(hslot == 8'd0, "R11 hslot", hslot, 0);
    chk(vline == '0, "R11 vline", vline, 0);
    chk(!hblank && !vblank, "R11 blanks", {hblank, vblank}, 0);
    chk(!line_adv && !vint_req, "R11 strobe/irq", {line_adv, vint_req}, 0);
    #1 rst_n = 1'b1;

    // Wide schedule, interrupt on first inactive line
    r0 = rises;
    wait_lines(9);
    chk(rises - r0 >= 1, "R8 wide mode5 rises", rises - r0, 1);

    // Switch width in mid-line
    while (hslot != 8'd100) @(negedge clk);
    #1 wide_mode = 1'b0;
    r0 = rises;
    wait_lines(9);
    chk(rises - r0 >= 1, "R8 narrow mode5 rises", rises - r0, 1);

    // Legacy interrupt line
    do @(negedge clk); while (!(line_adv && vline == VL_W'(1)));
    #1 mode5 = 1'b0;
    r0 = rises;
    wait_lines(8);
    chk(rises - r0 >= 1, "R8 legacy rises", rises - r0, 1);

    // Interrupt disabled
    #1 irq_en = 1'b0;
    r0 = rises;
    wait_lines(8);
    chk(rises - r0 == 0, "R9 no request while disabled", rises - r0, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule